// File: doc/BRIEF.md
# Half-Duplex Backpressure Jam Generator

This block sits next to the transmit side of one Ethernet MAC port and applies carrier-based flow control on a half-duplex link. When a remote station starts sending a frame and the switch has no receive buffer to hold it, the block sends a short jam burst onto the transmit nibble bus. The remote station sees a collision, backs off, and retries later, by which time a buffer may have become free.

All logic runs in the port's transmit clock domain. Carrier sense and collision come from the PHY with no relation to any clock, so they pass through a synchronizer first. A rising edge of the synchronized carrier, or of a synchronized collision in half-duplex, is a line event. A line event causes a jam only when backpressure is enabled, the link is half-duplex, no buffer is free and the MAC is not already transmitting a frame. The jam is 32 bits of alternating ones and zeros, sent as eight nibbles, and then transmit enable drops. The block jams at most once per line event and re-arms only after carrier and collision have both gone idle.

Top module: `bp_jam_gen`

## Requirements
- R1: While reset is high, and on the first sample after reset, `tx_en` is 0 and `txd` is 0.
- R2: A rising carrier with `full_duplex`=0, `bp_enable`=1, `buf_avail`=0 and `mac_tx_active`=0 makes `tx_en` go high in the third clock cycle after carrier is first sampled high (two synchronizer stages plus one edge-detect register).
- R3: A jam holds `tx_en` high for exactly 8 consecutive cycles with `txd`=4'h5 (bit 0 first, alternating 1,0,1,0) in every one of them, and then `tx_en` goes low.
- R4: Whenever `tx_en` is low, `txd` is 4'h0.
- R5: With `full_duplex`=1 no jam is produced, and the collision input has no effect.
- R6: With `bp_enable`=0 no jam is produced.
- R7: With `buf_avail`=1 at the line event no jam is produced.
- R8: At most one jam is produced per line event. A collision rising while the carrier is still high after a jam does not produce a second jam. A new carrier rise after carrier and collision have both been low for at least 3 cycles produces a new jam.
- R9: If `mac_tx_active` is high in the cycle the line event is detected, no jam is produced for that event, even if the MAC goes idle while carrier is still high.
- R10: In half-duplex, a rising collision with carrier low is a line event and produces a jam under the same conditions and with the same timing as R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port transmit clock |
| rst | input | 1 | Synchronous reset, active high |
| full_duplex | input | 1 | 1 when the port runs full-duplex |
| bp_enable | input | 1 | 1 enables backpressure |
| buf_avail | input | 1 | 1 when a receive buffer is free |
| mac_tx_active | input | 1 | 1 while the MAC is transmitting a frame |
| crs_async | input | 1 | Carrier sense from the PHY, asynchronous |
| col_async | input | 1 | Collision from the PHY, asynchronous |
| tx_en | output | 1 | Transmit enable, high during a jam |
| txd | output | 4 | Transmit nibble |

## Verification
The hardest situation to reach from the ports is a second line event that occurs inside one long carrier period after a jam has already fired. Random stimulus almost always drops carrier between events, so the once-per-event rule would go untested. Directed sequences therefore hold carrier high across the whole jam, raise collision in the middle of that carrier, and then release and re-raise carrier after a short idle gap. Further directed cases drop the MAC-busy flag just after the event, so that a jam which fires late would show up.

// File: rtl/bp_jam_pkg.sv
package bp_jam_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_JAM  = 1'b1
    } jam_state_e;

    typedef struct packed {
        logic crs;
        logic col;
    } line_sense_t;

    localparam int SENSE_W = $bits(line_sense_t);

    // Alternating pattern, bit 0 first: 1,0,1,0...
    function automatic logic [15:0] alt_pattern();
        logic [15:0] p;
        for (int i = 0; i < 16; i++) begin
            p[i] = (i % 2 == 0);
        end
        return p;
    endfunction

endpackage

// File: rtl/bp_sync.sv
module bp_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= '0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/bp_event.sv
module bp_event
    import bp_jam_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  line_sense_t sense,
    input  logic        full_duplex,
    input  logic        bp_enable,
    input  logic        buf_avail,
    input  logic        mac_tx_active,
    input  logic        seq_idle,
    output logic        fire
);
    logic col_eff;
    logic crs_q;
    logic col_q;
    logic armed;
    logic line_event;
    logic allowed;

    // Collision only counts on a half-duplex link
    assign col_eff    = sense.col & ~full_duplex;
    assign line_event = (sense.crs & ~crs_q) | (col_eff & ~col_q);
    assign allowed    = ~full_duplex & bp_enable & ~buf_avail & ~mac_tx_active;
    assign fire       = armed & line_event & allowed & seq_idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            crs_q <= 1'b0;
            col_q <= 1'b0;
            armed <= 1'b1;
        end else begin
            crs_q <= sense.crs;
            col_q <= col_eff;
            if (fire)
                armed <= 1'b0;
            else if (!sense.crs && !col_eff)
                armed <= 1'b1;
        end
    end
endmodule

// File: rtl/bp_jam_seq.sv
module bp_jam_seq
    import bp_jam_pkg::*;
#(
    parameter int NIBBLE_W = 4,
    parameter int JAM_BITS = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fire,
    output logic                seq_idle,
    output logic                tx_en,
    output logic [NIBBLE_W-1:0] txd
);
    localparam int JAM_BEATS = JAM_BITS / NIBBLE_W;
    localparam int CNT_W     = (JAM_BEATS > 1) ? $clog2(JAM_BEATS) : 1;
    localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(JAM_BEATS - 1);
    localparam logic [15:0] PAT_FULL = alt_pattern();
    localparam logic [NIBBLE_W-1:0] JAM_NIB = PAT_FULL[NIBBLE_W-1:0];

    jam_state_e       state;
    logic [CNT_W-1:0] beat;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            beat  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    beat <= '0;
                    if (fire) state <= ST_JAM;
                end
                ST_JAM: begin
                    if (beat == LAST_BEAT) begin
                        state <= ST_IDLE;
                        beat  <= '0;
                    end else begin
                        beat <= beat + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign seq_idle = (state == ST_IDLE);
    assign tx_en    = (state == ST_JAM);
    assign txd      = tx_en ? JAM_NIB : '0;
endmodule

// File: rtl/bp_jam_gen.sv
module bp_jam_gen
    import bp_jam_pkg::*;
#(
    parameter int NIBBLE_W    = 4,
    parameter int JAM_BITS    = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                full_duplex,
    input  logic                bp_enable,
    input  logic                buf_avail,
    input  logic                mac_tx_active,
    input  logic                crs_async,
    input  logic                col_async,
    output logic                tx_en,
    output logic [NIBBLE_W-1:0] txd
);
    line_sense_t raw_sense;
    line_sense_t sync_sense;
    logic        fire;
    logic        seq_idle;

    assign raw_sense.crs = crs_async;
    assign raw_sense.col = col_async;

    bp_sync #(
        .WIDTH  (SENSE_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_sense),
        .q   (sync_sense)
    );

    bp_event u_event (
        .clk           (clk),
        .rst           (rst),
        .sense         (sync_sense),
        .full_duplex   (full_duplex),
        .bp_enable     (bp_enable),
        .buf_avail     (buf_avail),
        .mac_tx_active (mac_tx_active),
        .seq_idle      (seq_idle),
        .fire          (fire)
    );

    bp_jam_seq #(
        .NIBBLE_W (NIBBLE_W),
        .JAM_BITS (JAM_BITS)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .seq_idle (seq_idle),
        .tx_en    (tx_en),
        .txd      (txd)
    );
endmodule

// File: rtl/bp_jam_checker.sv
module bp_jam_checker #(
    parameter int NIBBLE_W = 4,
    parameter int JAM_BITS = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                full_duplex,
    input logic                bp_enable,
    input logic                buf_avail,
    input logic                mac_tx_active,
    input logic                tx_en,
    input logic [NIBBLE_W-1:0] txd
);
    localparam int BEATS = JAM_BITS / NIBBLE_W;
    localparam int RUN_W = $clog2(BEATS + 2);
    localparam logic [NIBBLE_W-1:0] NIB = NIBBLE_W'(16'h5555);

    logic [RUN_W-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst)        run_len <= '0;
        else if (tx_en) run_len <= run_len + 1'b1;
        else            run_len <= '0;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> !tx_en);

    assert_jam_nibble_R3: assert property (@(posedge clk) disable iff (rst)
        tx_en |-> txd == NIB);

    assert_jam_run_R3: assert property (@(posedge clk) disable iff (rst)
        tx_en |-> run_len < RUN_W'(BEATS));

    assert_jam_len_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_en) |-> run_len == RUN_W'(BEATS));

    assert_idle_zero_R4: assert property (@(posedge clk) disable iff (rst)
        !tx_en |-> txd == '0);

    assert_fd_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_en) |-> !$past(full_duplex));

    assert_bp_off_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_en) |-> $past(bp_enable));

    assert_buf_free_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_en) |-> !$past(buf_avail));

    assert_mac_busy_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_en) |-> !$past(mac_tx_active));
endmodule

bind bp_jam_gen bp_jam_checker #(
    .NIBBLE_W (NIBBLE_W),
    .JAM_BITS (JAM_BITS)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .full_duplex   (full_duplex),
    .bp_enable     (bp_enable),
    .buf_avail     (buf_avail),
    .mac_tx_active (mac_tx_active),
    .tx_en         (tx_en),
    .txd           (txd)
);

// File: tb/test_bp_jam_gen.sv
module test_bp_jam_gen;
    localparam int LAT   = 3;
    localparam int BEATS = 8;
    localparam int WIN   = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       full_duplex = 1'b0;
    logic       bp_enable = 1'b1;
    logic       buf_avail = 1'b1;
    logic       mac_tx_active = 1'b0;
    logic       crs_async = 1'b0;
    logic       col_async = 1'b0;
    logic       tx_en;
    logic [3:0] txd;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bp_jam_gen i_bp_jam_gen (
        .clk           (clk),
        .rst           (rst),
        .full_duplex   (full_duplex),
        .bp_enable     (bp_enable),
        .buf_avail     (buf_avail),
        .mac_tx_active (mac_tx_active),
        .crs_async     (crs_async),
        .col_async     (col_async),
        .tx_en         (tx_en),
        .txd           (txd)
    );

    function automatic bit exp_fire(bit fd, bit bp, bit bf, bit busy, bit ec, bit el);
        bit ev = ec | (el & ~fd);
        return ev & ~fd & bp & ~bf & ~busy;
    endfunction

    function automatic string why(bit fd, bit bp, bit bf, bit busy, bit ec);
        if (fd)   return "R5";
        if (!bp)  return "R6";
        if (bf)   return "R7";
        if (busy) return "R9";
        return ec ? "R2" : "R10";
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Observe WIN samples; returns count of tx_en samples and first index
    task automatic observe(int drop_at, output int cnt, output int first);
        cnt = 0;
        first = -1;
        for (int i = 1; i <= WIN; i++) begin
            @(negedge clk);
            if (tx_en) begin
                if (first < 0) first = i;
                cnt++;
                check(txd == 4'h5, "R3", "jam nibble", int'(txd), 5);
            end else begin
                check(txd == 4'h0, "R4", "idle nibble", int'(txd), 0);
            end
            if (i == drop_at) begin
                crs_async = 1'b0;
                col_async = 1'b0;
            end
        end
    endtask

    task automatic idle_gap(int n);
        crs_async = 1'b0;
        col_async = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic run_event(bit fd, bit bp, bit bf, bit busy, bit ec, bit el, int hold);
        int cnt, first;
        bit f;
        string tag;
        @(negedge clk);
        full_duplex = fd; bp_enable = bp; buf_avail = bf; mac_tx_active = busy;
        @(negedge clk);
        crs_async = ec;
        col_async = el;
        observe(hold, cnt, first);
        f = exp_fire(fd, bp, bf, busy, ec, el);
        tag = why(fd, bp, bf, busy, ec);
        if (f) begin
            check(first == LAT, tag, "jam start sample", first, LAT);
            check(cnt == BEATS, "R3", "jam length", cnt, BEATS);
        end else begin
            check(cnt == 0, tag, "unexpected jam beats", cnt, 0);
        end
        idle_gap(5);
    endtask

    initial begin
        int cnt, first;
        void'($urandom(32'h1A2B3C4D));
        repeat (4) @(negedge clk);
        check(tx_en == 1'b0, "R1", "tx_en in reset", int'(tx_en), 0);
        check(txd == 4'h0, "R1", "txd in reset", int'(txd), 0);
        rst = 1'b0;
        @(negedge clk);
        check(tx_en == 1'b0, "R1", "tx_en after reset", int'(tx_en), 0);

        // Directed: basic carrier jam (R2, R3)
        run_event(0, 1, 0, 0, 1, 0, 2);
        // Directed: each inhibit (R5, R6, R7, R9)
        run_event(1, 1, 0, 0, 1, 0, 4);
        run_event(1, 1, 0, 0, 0, 1, 4);
        run_event(0, 0, 0, 0, 1, 0, 4);
        run_event(0, 1, 1, 0, 1, 0, 4);
        run_event(0, 1, 0, 1, 1, 0, 4);
        // Collision alone in half-duplex (R10)
        run_event(0, 1, 0, 0, 0, 1, 1);

        // R8: long carrier, then collision inside it, then re-raise
        @(negedge clk);
        full_duplex = 0; bp_enable = 1; buf_avail = 0; mac_tx_active = 0;
        @(negedge clk);
        crs_async = 1'b1;
        observe(0, cnt, first);
        check(cnt == BEATS, "R8", "first jam in long carrier", cnt, BEATS);
        col_async = 1'b1;
        observe(0, cnt, first);
        check(cnt == 0, "R8", "second jam in same carrier", cnt, 0);
        idle_gap(3);
        crs_async = 1'b1;
        observe(3, cnt, first);
        check(cnt == BEATS && first == LAT, "R8", "jam after re-arm", cnt, BEATS);
        idle_gap(5);

        // R9: MAC busy at event, then goes idle while carrier held
        @(negedge clk);
        mac_tx_active = 1'b1;
        @(negedge clk);
        crs_async = 1'b1;
        repeat (LAT) @(negedge clk);
        mac_tx_active = 1'b0;
        observe(0, cnt, first);
        check(cnt == 0, "R9", "late jam after MAC idle", cnt, 0);
        idle_gap(5);

        // Random mix
        for (int n = 0; n < 300; n++) begin
            bit fd   = ($urandom % 4) == 0;
            bit bp   = ($urandom % 5) != 0;
            bit bf   = ($urandom % 3) == 0;
            bit busy = ($urandom % 5) == 0;
            int kind = $urandom % 3;
            int hold = 1 + ($urandom % 14);
            run_event(fd, bp, bf, busy, kind != 1, kind != 0, hold);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule